// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is a small configuration space reached through a two-byte, 8-bit I/O window. Offset 0 is the index port, which names a register. Offset 1 is the data port, which reads or writes the register that the index port names. The space stays locked until the host writes the enter key to the index port on two index writes in a row. It locks again when the host writes the exit code 0xAA to the index port.

While the space is unlocked, the host can read the fixed identification bytes. It can also choose one of several logical devices through a device-select register. Each device has its own bank of registers: the I/O base, the interrupt mode, the RS485 line control and the FIFO control.

The host bus is a single-cycle synchronous strobe interface. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational and is valid in the same cycle as `bus_rd`.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the block is locked, the device select is 0, and every device bank holds its default values. The I/O base is 0x03F8, 0x02F8, 0x03E8 and 0x02E8 for devices 0 to 3, and every mode bit is 0.
- R2: Two index-port (offset 0) writes of the parameter `ENTER_KEY` in a row unlock the block. `ENTER_KEY` is one of 0x77, 0xA0, 0x87 or 0x67. Any other index-port write while the block is locked restarts the key matching. Data-port accesses do not take part in the matching.
- R3: While unlocked, an index-port write of 0xAA locks the block and leaves the stored index unchanged.
- R4: While locked, reads of either port return 0xFF, and data-port writes change no register.
- R5: While unlocked, an index-port write stores the index, and an index-port read returns it. When `bus_rd` is low, `bus_rdata` is 0.
- R6: Index 0x20 reads the low byte and 0x21 the high byte of the parameter `CHIP_ID`. Index 0x23 reads 0x19 and 0x24 reads 0x34. Writes to these four indexes have no effect.
- R7: Index 0x07 is the device select. A write keeps bits 1:0, and a read returns those bits with bits 7:2 at 0. Indexes 0x60 and above reach only the bank of the selected device.
- R8: In each bank, index 0x60 holds bits 15:8 and index 0x61 holds bits 7:0 of the 16-bit I/O base. Both are fully writable.
- R9: In each bank, index 0x70 is the interrupt mode. Bit 4 enables sharing and bits 6:5 give the trigger type (00 level/low, 01 edge/high). Only bits 6:4 are stored; the other bits read 0.
- R10: In each bank, index 0xF0 is the RS485 control. Bit 5 inverts RTS, bit 4 enables automatic direction, bit 3 enables the delay after transmit and bit 2 the delay before transmit. Only bits 5:2 are stored.
- R11: In each bank, index 0xF6 is the FIFO control. Bits 1:0 give the FIFO size (11 means 128 bytes) and bits 5:4 give the receive-threshold mode (10 means 4x). Only bits 5:4 and 1:0 are stored.
- R12: An unlocked data read of any other index returns 0, and a data write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | Port select: 0 index, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |

## Verification
The key matcher is driven with several patterns:
- a clean pair of keys;
- a key, a wrong byte, then a key, which must stay locked;
- a key followed by a data-port access and then a key, which must still unlock;
- three keys in a row, where the third must act as an index.

Together these separate a two-in-a-row matcher from one that merely counts keys or resets on any bus activity. The banked registers are written with different values in different devices and then read back after each device change, which exposes decoding that ignores the device select. All-ones writes to the masked registers show that only the defined bits are kept. Writes made while locked, both before the first unlock and after an exit, are checked after a later unlock to prove they had no effect.

// File: rtl/cfg_key_pkg.sv
// Package: shared constants, lock states and reset values for the keyed
// configuration port. Assumes 8-bit registers and a 1-bit port address.
package cfg_key_pkg;

    localparam logic [7:0] EXIT_CODE   = 8'hAA;
    localparam logic [7:0] IDX_DEVSEL  = 8'h07;
    localparam logic [7:0] IDX_CHIP_LO = 8'h20;
    localparam logic [7:0] IDX_CHIP_HI = 8'h21;
    localparam logic [7:0] IDX_VEND_A  = 8'h23;
    localparam logic [7:0] IDX_VEND_B  = 8'h24;
    localparam logic [7:0] VEND_A_VAL  = 8'h19;
    localparam logic [7:0] VEND_B_VAL  = 8'h34;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_IRQ     = 8'h70;
    localparam logic [7:0] IDX_LINE    = 8'hF0;
    localparam logic [7:0] IDX_FIFO    = 8'hF6;
    localparam logic [7:0] LOCKED_READ = 8'hFF;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_t;

    // Default I/O base of a device: steps down 0x100 on odd numbers, 0x10 per pair.
    function automatic logic [15:0] default_base(input int dev);
        logic [15:0] b;
        b = 16'h03F8;
        if ((dev % 2) == 1) b = b - 16'h0100;
        if (((dev / 2) % 2) == 1) b = b - 16'h0010;
        return b;
    endfunction

endpackage

// File: rtl/cfg_index_port.sv
// Index port and key lock: tracks the two-in-a-row enter key, the exit code
// and the index register. Assumes idx_wr is high only for offset-0 writes.
module cfg_index_port
    import cfg_key_pkg::*;
#(
    parameter logic [7:0] ENTER_KEY = 8'h77
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic [7:0] idx_q
);

    key_state_t state_q;

    // Lock state machine: key, key opens; a broken pair restarts; exit relocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_LOCKED;
        end else if (idx_wr) begin
            unique case (state_q)
                KS_LOCKED: state_q <= (wdata == ENTER_KEY) ? KS_HALF : KS_LOCKED;
                KS_HALF:   state_q <= (wdata == ENTER_KEY) ? KS_OPEN : KS_LOCKED;
                KS_OPEN:   state_q <= (wdata == EXIT_CODE) ? KS_LOCKED : KS_OPEN;
                default:   state_q <= KS_LOCKED;
            endcase
        end
    end

    // Index register: loaded by unlocked index writes other than the exit code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
        end else if (idx_wr && state_q == KS_OPEN && wdata != EXIT_CODE) begin
            idx_q <= wdata;
        end
    end

    assign unlocked = (state_q == KS_OPEN);

    // R2: unlocking always follows an index write of the key
    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(idx_wr && wdata == ENTER_KEY));

    // R3: the exit code always relocks
    a_r3_exit_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && idx_wr && wdata == EXIT_CODE) |=> !unlocked);

    // R3: exit code leaves the index untouched
    a_r3_exit_keeps_index: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && idx_wr && wdata == EXIT_CODE) |=> $stable(idx_q));

endmodule

// File: rtl/cfg_dev_bank.sv
// One logical device's register bank: I/O base, interrupt mode, RS485 line
// control and FIFO control. Assumes wr_en is already qualified by unlock and
// device select; read data is combinational for the current index.
module cfg_dev_bank
    import cfg_key_pkg::*;
#(
    parameter int DEV_NUM = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);

    localparam logic [15:0] BASE_RST = default_base(DEV_NUM);

    logic [15:0] base_q;
    logic [2:0]  irq_q;
    logic [3:0]  line_q;
    logic [1:0]  fifo_size_q;
    logic [1:0]  fifo_thr_q;

    // Register writes: each field keeps only its defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= BASE_RST;
            irq_q       <= '0;
            line_q      <= '0;
            fifo_size_q <= '0;
            fifo_thr_q  <= '0;
        end else if (wr_en) begin
            unique case (idx)
                IDX_BASE_HI: base_q[15:8] <= wdata;
                IDX_BASE_LO: base_q[7:0]  <= wdata;
                IDX_IRQ:     irq_q        <= wdata[6:4];
                IDX_LINE:    line_q       <= wdata[5:2];
                IDX_FIFO: begin
                    fifo_size_q <= wdata[1:0];
                    fifo_thr_q  <= wdata[5:4];
                end
                default: ;
            endcase
        end
    end

    // Read mux: undefined bits and unmapped indexes read as zero.
    always_comb begin
        unique case (idx)
            IDX_BASE_HI: rdata = base_q[15:8];
            IDX_BASE_LO: rdata = base_q[7:0];
            IDX_IRQ:     rdata = {1'b0, irq_q, 4'b0000};
            IDX_LINE:    rdata = {2'b00, line_q, 2'b00};
            IDX_FIFO:    rdata = {2'b00, fifo_thr_q, 2'b00, fifo_size_q};
            default:     rdata = 8'h00;
        endcase
    end

    // R8: the base only moves on a write to one of its two indexes
    a_r8_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (idx == IDX_BASE_HI || idx == IDX_BASE_LO)) |=> $stable(base_q));

    // R10: a line-control write lands the written bits
    a_r10_line_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_LINE) |=> line_q == $past(wdata[5:2]));

    // R9: the interrupt mode only moves on a write to its index
    a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && idx == IDX_IRQ) |=> $stable(irq_q));

endmodule

// File: rtl/cfg_key_port.sv
// Top: keyed two-byte configuration window. Combines the index/lock logic,
// the device select, fixed identification bytes and one bank per device.
// Assumes at most one of bus_wr/bus_rd per cycle and single-cycle strobes.
module cfg_key_port
    import cfg_key_pkg::*;
#(
    parameter logic [7:0]  ENTER_KEY = 8'h77,
    parameter logic [15:0] CHIP_ID   = 16'h1602,
    parameter int          NUM_DEV   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);

    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic             unlocked;
    logic [7:0]       idx_q;
    logic [DEV_W-1:0] devsel_q;
    logic             data_wr;
    logic [7:0]       bank_rdata [NUM_DEV];
    logic [7:0]       data_rd;

    cfg_index_port #(.ENTER_KEY(ENTER_KEY)) i_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (bus_wr && !bus_addr),
        .wdata    (bus_wdata),
        .unlocked (unlocked),
        .idx_q    (idx_q)
    );

    assign data_wr = bus_wr && bus_addr && unlocked;

    // Device select: low bits of an unlocked write to its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            devsel_q <= '0;
        end else if (data_wr && idx_q == IDX_DEVSEL) begin
            devsel_q <= bus_wdata[DEV_W-1:0];
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
        cfg_dev_bank #(.DEV_NUM(d)) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (data_wr && devsel_q == DEV_W'(d)),
            .idx   (idx_q),
            .wdata (bus_wdata),
            .rdata (bank_rdata[d])
        );
    end

    // Data-port read: global registers first, the selected bank otherwise.
    always_comb begin
        unique case (idx_q)
            IDX_DEVSEL:  data_rd = 8'(devsel_q);
            IDX_CHIP_LO: data_rd = CHIP_ID[7:0];
            IDX_CHIP_HI: data_rd = CHIP_ID[15:8];
            IDX_VEND_A:  data_rd = VEND_A_VAL;
            IDX_VEND_B:  data_rd = VEND_B_VAL;
            default:     data_rd = (idx_q >= IDX_BASE_HI) ? bank_rdata[devsel_q] : 8'h00;
        endcase
    end

    // Port read: zero when idle, all ones when locked.
    always_comb begin
        if (!bus_rd)        bus_rdata = 8'h00;
        else if (!unlocked) bus_rdata = LOCKED_READ;
        else if (!bus_addr) bus_rdata = idx_q;
        else                bus_rdata = data_rd;
    end

    // R4: locked reads return all ones
    a_r4_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_rd) |-> bus_rdata == LOCKED_READ);

    // R4: the device select cannot move while locked
    a_r4_locked_devsel: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(devsel_q));

    // R5: idle bus reads zero
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 8'h00);

endmodule

// File: tb/test_cfg_key_port.sv
// Bench: behavioural reference model of the keyed port, compared every clock.
module test_cfg_key_port;

    localparam int          CLK_P  = 10;
    localparam logic [7:0]  KEY    = 8'h87;
    localparam logic [15:0] CHIPID = 16'h1602;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_wr = 0;
    logic       bus_rd = 0;
    logic       bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int          m_state = 0;   // 0 locked, 1 one key seen, 2 open
    logic [7:0]  m_idx = 0;
    int          m_dev = 0;
    logic [15:0] m_base [4];
    logic [7:0]  m_irq [4];
    logic [7:0]  m_line [4];
    logic [7:0]  m_fifo [4];

    cfg_key_port #(.ENTER_KEY(KEY), .CHIP_ID(CHIPID), .NUM_DEV(4)) i_cfg_key_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] model_read(input logic rd, input logic a);
        if (!rd) return 8'h00;
        if (m_state != 2) return 8'hFF;
        if (!a) return m_idx;
        case (m_idx)
            8'h07: return 8'(m_dev);
            8'h20: return CHIPID[7:0];
            8'h21: return CHIPID[15:8];
            8'h23: return 8'h19;
            8'h24: return 8'h34;
            8'h60: return m_base[m_dev][15:8];
            8'h61: return m_base[m_dev][7:0];
            8'h70: return m_irq[m_dev];
            8'hF0: return m_line[m_dev];
            8'hF6: return m_fifo[m_dev];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_state = 0; m_idx = 0; m_dev = 0;
        m_base[0] = 16'h03F8; m_base[1] = 16'h02F8;
        m_base[2] = 16'h03E8; m_base[3] = 16'h02E8;
        for (int i = 0; i < 4; i++) begin
            m_irq[i] = 0; m_line[i] = 0; m_fifo[i] = 0;
        end
    endtask

    task automatic model_write(input logic a, input logic [7:0] d);
        if (!a) begin
            case (m_state)
                0: m_state = (d == KEY) ? 1 : 0;
                1: m_state = (d == KEY) ? 2 : 0;
                default: if (d == 8'hAA) m_state = 0; else m_idx = d;
            endcase
        end else if (m_state == 2) begin
            case (m_idx)
                8'h07: m_dev = int'(d[1:0]);
                8'h60: m_base[m_dev][15:8] = d;
                8'h61: m_base[m_dev][7:0] = d;
                8'h70: m_irq[m_dev] = d & 8'h70;
                8'hF0: m_line[m_dev] = d & 8'h3C;
                8'hF6: m_fifo[m_dev] = d & 8'h33;
                default: ;
            endcase
        end
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the read port against the model.
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) check("R5 per-cycle", bus_rdata, model_read(bus_rd, bus_addr));
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic a, input string req, input logic [7:0] exp);
        @(negedge clk);
        bus_rd = 1; bus_wr = 0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic rdreg(input logic [7:0] ix, input string req, input logic [7:0] exp);
        wr(0, ix);
        rd(1, req, exp);
    endtask

    task automatic unlock();
        wr(0, KEY);
        wr(0, KEY);
    endtask

    task automatic finish_up();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog: got hang expected completion");
        finish_up();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 / R4: locked after reset
        rd(0, "R1 locked index read", 8'hFF);
        rd(1, "R4 locked data read", 8'hFF);
        // R4: locked data write, verified after unlock
        wr(1, 8'h55);
        // R2: key, wrong byte, key stays locked
        wr(0, KEY); wr(0, 8'h12); wr(0, KEY);
        rd(1, "R2 broken pair stays locked", 8'hFF);
        // R2: second key completes unlock
        wr(0, KEY);
        rd(0, "R2 unlocked index read", 8'h00);
        rdreg(8'h07, "R1 devsel reset", 8'h00);
        rdreg(8'h61, "R1 base lo dev0", 8'hF8);
        rdreg(8'h60, "R1 base hi dev0", 8'h03);
        // R6: identification
        rdreg(8'h20, "R6 chip lo", CHIPID[7:0]);
        rdreg(8'h21, "R6 chip hi", CHIPID[15:8]);
        rdreg(8'h23, "R6 vendor a", 8'h19);
        rdreg(8'h24, "R6 vendor b", 8'h34);
        wr(0, 8'h20); wr(1, 8'h00);
        rd(1, "R6 write ignored", CHIPID[7:0]);
        // R1 / R7: defaults of every device
        for (int d = 0; d < 4; d++) begin
            wr(0, 8'h07); wr(1, 8'(d));
            rd(1, "R7 devsel readback", 8'(d));
            rdreg(8'h60, "R1 base hi", m_base[d][15:8]);
            rdreg(8'h61, "R1 base lo", m_base[d][7:0]);
            rdreg(8'h70, "R1 irq reset", 8'h00);
            rdreg(8'hF6, "R1 fifo reset", 8'h00);
        end
        // R7: upper bits dropped
        wr(0, 8'h07); wr(1, 8'hFE);
        rd(1, "R7 devsel masked", 8'h02);
        // R8..R11: distinct values per device
        for (int d = 0; d < 4; d++) begin
            wr(0, 8'h07); wr(1, 8'(d));
            wr(0, 8'h60); wr(1, 8'h10 + 8'(d));
            wr(0, 8'h61); wr(1, 8'hA0 + 8'(d));
            wr(0, 8'h70); wr(1, (d % 2 == 1) ? 8'hFF : 8'h20);
            wr(0, 8'hF0); wr(1, (d == 2) ? 8'hFF : 8'h14);
            wr(0, 8'hF6); wr(1, (d == 3) ? 8'hFF : 8'h23);
        end
        for (int d = 3; d >= 0; d--) begin
            wr(0, 8'h07); wr(1, 8'(d));
            rdreg(8'h60, "R8 base hi banked", 8'h10 + 8'(d));
            rdreg(8'h61, "R8 base lo banked", 8'hA0 + 8'(d));
            rdreg(8'h70, "R9 irq masked", (d % 2 == 1) ? 8'h70 : 8'h20);
            rdreg(8'hF0, "R10 line masked", (d == 2) ? 8'h3C : 8'h14);
            rdreg(8'hF6, "R11 fifo masked", (d == 3) ? 8'h33 : 8'h23);
        end
        // R12: unmapped index
        wr(0, 8'h62); wr(1, 8'h5A);
        rd(1, "R12 unmapped read", 8'h00);
        rdreg(8'h30, "R12 unmapped low", 8'h00);
        // R3: exit relocks, locked write ignored
        wr(0, 8'h61);
        wr(0, 8'hAA);
        rd(0, "R3 relocked", 8'hFF);
        wr(1, 8'h00);
        // R2: data access between keys does not break the pair
        wr(0, KEY); rd(1, "R4 locked mid-key", 8'hFF); wr(0, KEY);
        rd(0, "R3 index kept", 8'h61);
        rd(1, "R4 write while relocked ignored", 8'hA0);
        // R2: third key acts as an index write
        wr(0, 8'hAA);
        wr(0, KEY); wr(0, KEY); wr(0, KEY);
        rd(0, "R2 third key is index", KEY);
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule